// File: doc/BRIEF.md
# Static Fallback Branch Resteer Unit

This unit sits at the instruction queue, the earliest pipeline point where instruction boundaries and branch kinds are known. For every decoded branch it decides a final direction. When the dynamic target lookup hit, the dynamic direction is passed through unchanged. When a conditional branch missed that lookup, a static rule chooses the direction instead. An optional second-level hint can override that rule.

A static not-taken guess does nothing, and fetch keeps running down the sequential path. A static taken guess raises a one-cycle front-end clear that flushes everything above the queue. Fetch is then held for a fixed bubble. When the bubble ends, fetch is redirected to a target built from the branch PC, the instruction length and the sign-extended displacement. A saturating event counter records each forced clear. Software can read the counter and zero it through a plain count/clear pair.

Top module: `sfr_resteer_top`

## Requirements
- R1: One cycle after a branch is presented (`br_valid`=1), `pred_valid` pulses high for one cycle. If `br_btb_hit`=1, `pred_taken` equals `br_dyn_taken`, and no clear is raised.
- R2: For a conditional branch (`br_cond`=1) that missed (`br_btb_hit`=0) with no hint, the direction is taken exactly when the displacement is negative (its MSB is 1).
- R3: With `USE_HINT`=1 (the default), a missed conditional branch with `hint_valid`=1 takes `hint_taken` as its direction, whatever the sign of the displacement.
- R4: A static not-taken outcome produces no clear, no stall and no redirect.
- R5: A static taken outcome on a missed conditional branch, when the unit is idle, raises `fe_clear` for exactly one cycle, one cycle after the branch is presented. `fetch_stall` is high in that same cycle.
- R6: `fetch_stall` stays high for exactly `BUBBLE_CYC` consecutive cycles (8 by default), starting with the `fe_clear` cycle.
- R7: In the cycle right after `fetch_stall` falls, `redir_valid` is high for exactly one cycle. In that cycle `redir_pc` = `br_pc` + `br_len` + sign-extended `br_disp`, modulo 2^`ADDR_W`.
- R8: An unconditional branch (`br_cond`=0) is predicted taken (`pred_taken`=1). It never raises a clear and never changes the counter.
- R9: A forcing request that arrives while the stall or the redirect cycle is in progress is ignored. It raises no clear, does not count, and leaves the pending redirect target and timing unchanged.
- R10: `evt_count` is 0 after reset and goes up by one, one cycle after each forced clear.
- R11: `evt_count` saturates at all ones and does not wrap.
- R12: `evt_clear`=1 zeroes `evt_count` on the next cycle. It wins over an increment in the same cycle.
- R13: While reset is held, `pred_valid`, `fe_clear`, `fetch_stall`, `redir_valid` and `evt_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A decoded branch is presented this cycle |
| br_cond | input | 1 | Branch is conditional |
| br_btb_hit | input | 1 | Dynamic target lookup hit for this branch |
| br_dyn_taken | input | 1 | Dynamic direction, used on a hit |
| hint_valid | input | 1 | Second-level direction hint present |
| hint_taken | input | 1 | Second-level hint direction |
| br_pc | input | ADDR_W | Branch instruction address |
| br_len | input | LEN_W | Branch instruction length in bytes |
| br_disp | input | DISP_W | Signed displacement from the encoding |
| evt_clear | input | 1 | Zero the forced-clear counter |
| pred_valid | output | 1 | Direction result valid |
| pred_taken | output | 1 | Final direction |
| fe_clear | output | 1 | Front-end flush pulse |
| fetch_stall | output | 1 | Fetch held during the bubble |
| redir_valid | output | 1 | Fetch redirect valid |
| redir_pc | output | ADDR_W | Redirect target address |
| evt_count | output | CNT_W | Forced-clear event count |

## Verification
A wrong bubble count shows at the ports as a `fetch_stall` window that is too short or too long. It also moves the `redir_valid` pulse, so it is visible within `BUBBLE_CYC`+1 cycles of the clear. A busy flag that drops too early lets a second clear through mid-bubble. That shows one cycle after the injected request, as an extra `fe_clear` and an extra count. A corrupted latched target shows only in the single redirect cycle. So the bench compares `redir_pc` exactly in that cycle, including after a competing request during the bubble.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
   typedef enum logic [1:0] {
      BUB_IDLE  = 2'd0,
      BUB_STALL = 2'd1,
      BUB_REDIR = 2'd2
   } bub_state_e;
endpackage

// File: rtl/sfr_dir_pick.sv
`timescale 1ns/1ps
module sfr_dir_pick #(
   parameter int USE_HINT = 1
) (
   input  logic cond_i,
   input  logic hit_i,
   input  logic dyn_taken_i,
   input  logic hint_valid_i,
   input  logic hint_taken_i,
   input  logic disp_neg_i,
   output logic taken_o,
   output logic force_o
);
   localparam bit HINT_ON = (USE_HINT != 0);

   logic use_hint;
   logic static_dir;

   if (USE_HINT < 0 || USE_HINT > 1) begin : g_bad_hint
      $error("sfr_dir_pick: USE_HINT must be 0 or 1");
   end

   assign use_hint   = HINT_ON & hint_valid_i;
   // backward-taken / forward-not-taken, optionally overridden by hint
   assign static_dir = use_hint ? hint_taken_i : disp_neg_i;

   always_comb begin
      if (!cond_i) begin
         taken_o = 1'b1;
         force_o = 1'b0;
      end else if (hit_i) begin
         taken_o = dyn_taken_i;
         force_o = 1'b0;
      end else begin
         taken_o = static_dir;
         force_o = static_dir;
      end
   end
endmodule

// File: rtl/sfr_tgt_calc.sv
`timescale 1ns/1ps
module sfr_tgt_calc #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int LEN_W  = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] tgt_o
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] len_ext;

   if (ADDR_W <= DISP_W) begin : g_bad_disp
      $error("sfr_tgt_calc: ADDR_W must exceed DISP_W");
   end
   if (ADDR_W <= LEN_W) begin : g_bad_len
      $error("sfr_tgt_calc: ADDR_W must exceed LEN_W");
   end

   assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
   assign len_ext  = {{(ADDR_W-LEN_W){1'b0}}, len_i};
   assign tgt_o    = pc_i + len_ext + disp_ext;
endmodule

// File: rtl/sfr_bubble_ctrl.sv
`timescale 1ns/1ps
module sfr_bubble_ctrl
   import sfr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BUBBLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] tgt_i,
   output logic              accept_o,
   output logic              stall_o,
   output logic              redir_valid_o,
   output logic [ADDR_W-1:0] redir_pc_o
);
   localparam int BW = (BUBBLE_CYC > 2) ? $clog2(BUBBLE_CYC) : 1;
   localparam logic [BW-1:0] LOAD = BW'(BUBBLE_CYC - 1);

   if (BUBBLE_CYC < 2) begin : g_bad_bubble
      $error("sfr_bubble_ctrl: BUBBLE_CYC must be at least 2");
   end

   bub_state_e        state_q;
   logic [BW-1:0]     cnt_q;
   logic [ADDR_W-1:0] tgt_q;

   assign accept_o      = start_i && (state_q == BUB_IDLE);
   assign stall_o       = (state_q == BUB_STALL);
   assign redir_valid_o = (state_q == BUB_REDIR);
   assign redir_pc_o    = tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BUB_IDLE;
         cnt_q   <= '0;
         tgt_q   <= '0;
      end else begin
         case (state_q)
            BUB_IDLE: begin
               if (start_i) begin
                  state_q <= BUB_STALL;
                  cnt_q   <= LOAD;
                  tgt_q   <= tgt_i;
               end
            end
            BUB_STALL: begin
               if (cnt_q == '0) state_q <= BUB_REDIR;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= BUB_IDLE;
         endcase
      end
   end

   AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid_o |=> !redir_valid_o);                          // R7
   AST_REDIR_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid_o |-> $past(stall_o));                          // R7
   AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && $past(stall_o)) |-> $stable(redir_pc_o));       // R9
endmodule

// File: rtl/sfr_evt_ctr.sv
`timescale 1ns/1ps
module sfr_evt_ctr #(
   parameter int CNT_W    = 32,
   parameter int SATURATE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             may_inc;

   if (CNT_W < 1) begin : g_bad_w
      $error("sfr_evt_ctr: CNT_W must be positive");
   end

   if (SATURATE != 0) begin : g_sat
      assign may_inc = inc_i && (cnt_q != MAXV);
   end else begin : g_wrap
      assign may_inc = inc_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (may_inc) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;

   if (SATURATE != 0) begin : g_sat_chk
      AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == MAXV && !clear_i) |=> (cnt_q == MAXV));        // R11
   end
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_q == '0));                                 // R12
endmodule

// File: rtl/sfr_resteer_top.sv
`timescale 1ns/1ps
module sfr_resteer_top #(
   parameter int ADDR_W     = 32,
   parameter int DISP_W     = 16,
   parameter int LEN_W      = 4,
   parameter int BUBBLE_CYC = 8,
   parameter int CNT_W      = 32,
   parameter int USE_HINT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid,
   input  logic              br_cond,
   input  logic              br_btb_hit,
   input  logic              br_dyn_taken,
   input  logic              hint_valid,
   input  logic              hint_taken,
   input  logic [ADDR_W-1:0] br_pc,
   input  logic [LEN_W-1:0]  br_len,
   input  logic [DISP_W-1:0] br_disp,
   input  logic              evt_clear,
   output logic              pred_valid,
   output logic              pred_taken,
   output logic              fe_clear,
   output logic              fetch_stall,
   output logic              redir_valid,
   output logic [ADDR_W-1:0] redir_pc,
   output logic [CNT_W-1:0]  evt_count
);
   logic              dir_taken;
   logic              dir_force;
   logic              start_req;
   logic              accepted;
   logic [ADDR_W-1:0] tgt;
   logic              pv_q, pt_q, clr_q;

   sfr_dir_pick #(.USE_HINT(USE_HINT)) u_dir (
      .cond_i       (br_cond),
      .hit_i        (br_btb_hit),
      .dyn_taken_i  (br_dyn_taken),
      .hint_valid_i (hint_valid),
      .hint_taken_i (hint_taken),
      .disp_neg_i   (br_disp[DISP_W-1]),
      .taken_o      (dir_taken),
      .force_o      (dir_force)
   );

   sfr_tgt_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_tgt (
      .pc_i   (br_pc),
      .len_i  (br_len),
      .disp_i (br_disp),
      .tgt_o  (tgt)
   );

   assign start_req = br_valid && dir_force;

   sfr_bubble_ctrl #(.ADDR_W(ADDR_W), .BUBBLE_CYC(BUBBLE_CYC)) u_bub (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_req),
      .tgt_i         (tgt),
      .accept_o      (accepted),
      .stall_o       (fetch_stall),
      .redir_valid_o (redir_valid),
      .redir_pc_o    (redir_pc)
   );

   sfr_evt_ctr #(.CNT_W(CNT_W), .SATURATE(1)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (accepted),
      .clear_i (evt_clear),
      .count_o (evt_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pv_q  <= 1'b0;
         pt_q  <= 1'b0;
         clr_q <= 1'b0;
      end else begin
         pv_q  <= br_valid;
         pt_q  <= br_valid && dir_taken;
         clr_q <= accepted;
      end
   end

   assign pred_valid = pv_q;
   assign pred_taken = pt_q;
   assign fe_clear   = clr_q;

   AST_CLR_ONLY_COND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      fe_clear |-> $past(br_valid && br_cond && !br_btb_hit));    // R8
   AST_CLR_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      fe_clear |-> (fetch_stall && pred_taken));                  // R5
   AST_NO_CLR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fe_clear |-> !($past(fetch_stall) || $past(redir_valid)));  // R9
   AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fe_clear |=> !fe_clear);                                    // R5
endmodule

// File: tb/sfr_resteer_top_tb_top.sv
`timescale 1ns/1ps
module sfr_resteer_top_tb_top;
   localparam int BUB = 8;
   localparam int CW  = 3;
   localparam logic [CW-1:0] CMAX = '1;

   typedef struct packed {
      logic        cond;
      logic        hit;
      logic        dyn;
      logic        hv;
      logic        ht;
      logic [15:0] disp;
      logic [3:0]  len;
      logic [31:0] pc;
      logic        e_taken;
      logic        e_clr;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b1,1'b1,1'b1,1'b0,1'b0,16'h0020,4'd2,32'h0000_0100,1'b1,1'b0},
      '{1'b1,1'b1,1'b0,1'b0,1'b0,16'hFFF0,4'd2,32'h0000_0200,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,16'hFFF0,4'd2,32'h0000_1000,1'b1,1'b1},
      '{1'b1,1'b0,1'b1,1'b0,1'b0,16'h0020,4'd2,32'h0000_1100,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b1,1'b1,16'h0020,4'd6,32'h0000_2000,1'b1,1'b1},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,16'hFF00,4'd3,32'h0000_3000,1'b0,1'b0},
      '{1'b0,1'b0,1'b0,1'b0,1'b0,16'hFFF0,4'd5,32'h0000_5000,1'b1,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h8000,4'd4,32'h0000_0010,1'b1,1'b1}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic br_valid, br_cond, br_btb_hit, br_dyn_taken, hint_valid, hint_taken;
   logic [31:0] br_pc;
   logic [3:0]  br_len;
   logic [15:0] br_disp;
   logic evt_clear;
   logic pred_valid, pred_taken, fe_clear, fetch_stall, redir_valid;
   logic [31:0] redir_pc;
   logic [CW-1:0] evt_count;

   int checks = 0;
   int errors = 0;
   logic [CW-1:0] exp_cnt;

   always #2.5 clk = ~clk;

   sfr_resteer_top #(.CNT_W(CW), .BUBBLE_CYC(BUB)) dut_i (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
      .br_btb_hit(br_btb_hit), .br_dyn_taken(br_dyn_taken),
      .hint_valid(hint_valid), .hint_taken(hint_taken), .br_pc(br_pc),
      .br_len(br_len), .br_disp(br_disp), .evt_clear(evt_clear),
      .pred_valid(pred_valid), .pred_taken(pred_taken), .fe_clear(fe_clear),
      .fetch_stall(fetch_stall), .redir_valid(redir_valid),
      .redir_pc(redir_pc), .evt_count(evt_count)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] tgt_of(input logic [31:0] pc, input logic [3:0] len,
                                          input logic [15:0] disp);
      return pc + {28'd0, len} + {{16{disp[15]}}, disp};
   endfunction

   function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
      return (c == CMAX) ? c : c + 1'b1;
   endfunction

   task automatic drive(input logic c, h, d, hv, ht, input logic [15:0] disp,
                        input logic [3:0] len, input logic [31:0] pc);
      br_valid = 1'b1; br_cond = c; br_btb_hit = h; br_dyn_taken = d;
      hint_valid = hv; hint_taken = ht; br_disp = disp; br_len = len; br_pc = pc;
   endtask

   // send a forcing branch, then wait out stall and redirect
   task automatic force_and_wait(input logic [31:0] pc);
      @(negedge clk); drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFC, 4'd2, pc);
      @(negedge clk); br_valid = 1'b0;
      repeat (BUB + 1) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; evt_clear = 1'b0;
      br_valid = 1'b0; br_cond = 1'b0; br_btb_hit = 1'b0; br_dyn_taken = 1'b0;
      hint_valid = 1'b0; hint_taken = 1'b0; br_pc = '0; br_len = '0; br_disp = '0;
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 pred_valid", 32'(pred_valid), 0);
      check("R13 fe_clear", 32'(fe_clear), 0);
      check("R13 fetch_stall", 32'(fetch_stall), 0);
      check("R13 redir_valid", 32'(redir_valid), 0);
      check("R13 R10 evt_count", 32'(evt_count), 0);
      rst_n = 1'b1;
      exp_cnt = '0;

      // vector table: R1 R2 R3 R4 R5 R6 R7 R8 R10
      for (int i = 0; i < 8; i++) begin
         vec_t v;
         v = VECS[i];
         @(negedge clk);
         drive(v.cond, v.hit, v.dyn, v.hv, v.ht, v.disp, v.len, v.pc);
         @(negedge clk); br_valid = 1'b0;
         check("R1 pred_valid", 32'(pred_valid), 1);
         check("R1 R2 R3 R8 pred_taken", 32'(pred_taken), 32'(v.e_taken));
         check("R4 R5 R8 fe_clear", 32'(fe_clear), 32'(v.e_clr));
         if (v.e_clr) exp_cnt = bump(exp_cnt);
         check("R10 evt_count", 32'(evt_count), 32'(exp_cnt));
         if (v.e_clr) begin
            check("R5 stall with clear", 32'(fetch_stall), 1);
            for (int k = 1; k < BUB; k++) begin
               @(negedge clk);
               check("R6 stall held", 32'(fetch_stall), 1);
               check("R6 no early redirect", 32'(redir_valid), 0);
               check("R5 clear one cycle", 32'(fe_clear), 0);
            end
            @(negedge clk);
            check("R6 stall ends", 32'(fetch_stall), 0);
            check("R7 redirect valid", 32'(redir_valid), 1);
            check("R7 redirect pc", redir_pc, tgt_of(v.pc, v.len, v.disp));
            @(negedge clk);
            check("R7 redirect one cycle", 32'(redir_valid), 0);
         end else begin
            check("R4 no stall", 32'(fetch_stall), 0);
            @(negedge clk);
            check("R4 no redirect", 32'(redir_valid), 0);
            check("R1 pred one cycle", 32'(pred_valid), 0);
         end
      end

      // R9: request during stall and during redirect ignored
      @(negedge clk); drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFC, 4'd2, 32'h0000_4000);
      @(negedge clk); br_valid = 1'b0;
      check("R9 first clear", 32'(fe_clear), 1);
      exp_cnt = bump(exp_cnt);
      for (int k = 2; k <= BUB; k++) begin
         @(negedge clk);
         if (k == 3) begin
            check("R9 no clear in bubble", 32'(fe_clear), 0);
            check("R9 no count in bubble", 32'(evt_count), 32'(exp_cnt));
         end
         check("R9 R6 stall length kept", 32'(fetch_stall), 1);
         if (k == 2) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFE, 4'd4, 32'h0000_8000);
         else br_valid = 1'b0;
      end
      @(negedge clk);
      check("R9 redirect on time", 32'(redir_valid), 1);
      check("R9 target kept", redir_pc, 32'h0000_3FFE);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFF8, 4'd2, 32'h0000_9000);
      @(negedge clk); br_valid = 1'b0;
      check("R9 no clear in redirect cycle", 32'(fe_clear), 0);
      check("R9 no stall after redirect", 32'(fetch_stall), 0);
      check("R9 count unchanged", 32'(evt_count), 32'(exp_cnt));

      // R12: clear, and clear beats a same-cycle increment
      @(negedge clk); evt_clear = 1'b1;
      @(negedge clk); evt_clear = 1'b0;
      check("R12 cleared", 32'(evt_count), 0);
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFC, 4'd2, 32'h0000_6000);
      evt_clear = 1'b1;
      @(negedge clk); br_valid = 1'b0; evt_clear = 1'b0;
      check("R12 clear wins", 32'(evt_count), 0);
      check("R12 clear still raised", 32'(fe_clear), 1);
      repeat (BUB + 1) @(negedge clk);

      // R11 saturation
      exp_cnt = '0;
      for (int n = 0; n < 9; n++) begin
         force_and_wait(32'h0000_7000 + 32'(n * 16));
         exp_cnt = bump(exp_cnt);
         check("R11 R10 count step", 32'(evt_count), 32'(exp_cnt));
      end
      check("R11 saturated", 32'(evt_count), 32'(CMAX));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule